// File: doc/BRIEF.md
# SDRAM Burst Data-Phase Sequencer

This block drives the data phase of one SDRAM burst on a row that is already open. The controller hands it a request: bank, starting column, direction, fixed or full-page length, an optional early-stop count and an auto-precharge choice. The block then puts the READ or WRITE command on the command bus, followed by NOP cycles and, where the burst is cut short, a BURST TERMINATE. During a write it pulls one word per cycle from a ready/valid source straight onto the data bus. During a read it captures the returning words after the CAS latency and hands them to a sink, each tagged with its column.

The burst length (1, 2, 4 or 8) and the CAS latency (2 or 3) come from static configuration inputs. These must match what the memory's mode register holds, and they change only while the block is idle. Fixed bursts walk their columns inside the aligned block of the burst length. Full-page bursts walk the whole page, wrap from the last column to column 0, and stop only when the early-stop count issues a terminate. When auto-precharge is used, a one-cycle pulse at the end of the burst tells the row tracker that the bank is now closed.

Top module: `sdram_burst_seq`

## Requirements
- R1: Commands are coded on `cmd_n` as {chip select, row strobe, column strobe, write enable}, all active low: NOP = 0111, READ = 0101, WRITE = 0100, BURST TERMINATE = 0110. READ or WRITE appears in the first cycle after a request is accepted, with the request's bank on `cmd_bank` and its start column on `cmd_col`. `cmd_col` is zero in every other cycle.
- R2: In a write burst the first word goes out in the WRITE cycle and each later word in the following cycles. In each such cycle `dq_oe` and `wr_ready` are high and `dq_out` equals `wr_data`. In a read burst `dq_oe` stays low.
- R3: After the last word of a write burst, `dq_oe` and `wr_ready` drop in the next cycle, so the bus is released and no more source data is taken.
- R4: `cfg_bl_sel` selects the fixed burst length as 2 to the power `cfg_bl_sel` (0:1, 1:2, 2:4, 3:8). Word k of a fixed burst uses the column whose upper bits are those of the start column and whose low log2(length) bits are (start + k) modulo the length. This column is reported on `wr_col` or `rd_col`.
- R5: A full-page request (`req_full_page` = 1) walks the columns as (start + k) modulo the page size, wrapping from the last column to 0. It ends with BURST TERMINATE in cycle S after the command, where S is the stop count.
- R6: `cfg_cl3` = 0 means CAS latency 2 and 1 means latency 3. Read word k is sampled from `dq_in` CAS-latency + k cycles after the READ cycle. It is presented on `rd_data` with `rd_valid` high one cycle later.
- R7: A fixed request with `req_stop_en` set, auto-precharge off and stop count S below the burst length issues BURST TERMINATE S cycles after the command. A read then delivers exactly S words: latency minus one of them arrive after the terminate.
- R8: With `req_auto_pre` set on a fixed burst, `cmd_ap` is high in the command cycle and the early stop is ignored. `pre_done` pulses for one cycle, with the bank on `pre_bank`, in the first cycle that `busy` is low. Full-page bursts never use auto-precharge.
- R9: `busy` goes high in the command cycle. It stays high until the bus is released after a write (including any terminate cycle) or until the last read word is presented. While `busy` is high, requests are ignored.
- R10: On a write beat where `wr_valid` is low, `dqm` is high for that cycle so the memory masks the word. Otherwise `dqm` is low.
- R11: A stop count of zero is treated as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bl_sel | input | 2 | Fixed burst length select (length = 2^value) |
| cfg_cl3 | input | 1 | CAS latency: 0 = 2, 1 = 3 |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_full_page | input | 1 | Full-page burst instead of fixed length |
| req_auto_pre | input | 1 | Auto-precharge at the end of a fixed burst |
| req_stop_en | input | 1 | Enable early stop by terminate |
| req_stop_cnt | input | COL_W+1 | Words to transfer before the terminate |
| req_bank | input | BANK_W | Bank address |
| req_col | input | COL_W | Starting column |
| busy | output | 1 | Burst in progress |
| cmd_n | output | 4 | Command {CS#, RAS#, CAS#, WE#} |
| cmd_bank | output | BANK_W | Bank address of the burst |
| cmd_col | output | COL_W | Column address in the command cycle |
| cmd_ap | output | 1 | Auto-precharge address bit |
| wr_valid | input | 1 | Write source has a word |
| wr_data | input | DATA_W | Write source word |
| wr_ready | output | 1 | Write word taken this cycle |
| wr_col | output | COL_W | Column of the current write word |
| dq_out | output | DATA_W | Data bus output |
| dq_oe | output | 1 | Data bus output enable |
| dqm | output | 1 | Data mask |
| dq_in | input | DATA_W | Data bus input |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | DATA_W | Read word |
| rd_col | output | COL_W | Column of the read word |
| pre_done | output | 1 | Bank closed by auto-precharge (pulse) |
| pre_bank | output | BANK_W | Bank that was closed |

## Verification
The bench targets column wrap at both levels. It starts a fixed burst in the middle of its aligned block, where a design that carried into the upper bits would walk out of the block. It starts a full-page burst next to the last column, where a design without page wrap would emit out-of-range columns. Early stops under both latencies check that a read delivers exactly the stop count. A capture window trimmed wrongly after the terminate would drop the last word or take one stale word. It also checks write release, a request held high during a busy burst, a masked beat, an auto-precharge request that also asks for an early stop, and a zero stop count. Each would show up as a leftover driven cycle, a second command, a missing mask, a stray terminate or a terminate in the command cycle.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [3:0] {
    CMD_NOP   = 4'b0111,
    CMD_READ  = 4'b0101,
    CMD_WRITE = 4'b0100,
    CMD_BST   = 4'b0110
  } sdr_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_TERM  = 2'd2,
    ST_DRAIN = 2'd3
  } seq_state_e;

  localparam int unsigned LAT_MAX = 3;

endpackage

// File: rtl/sdram_burst_plan.sv
module sdram_burst_plan #(
  parameter int CNT_W = 11
) (
  input  logic             full,
  input  logic             ap,
  input  logic             stop_en,
  input  logic [CNT_W-1:0] stop_cnt,
  input  logic [1:0]       bl_sel,
  output logic [CNT_W-1:0] n_words,
  output logic             need_term,
  output logic             endless,
  output logic             ap_eff
);
  logic [CNT_W-1:0] bl_len;
  logic [CNT_W-1:0] s_eff;

  always_comb begin
    bl_len = '0;
    bl_len[bl_sel] = 1'b1;
    s_eff = (stop_cnt == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : stop_cnt;
    if (full) begin
      n_words   = s_eff;
      need_term = stop_en;
      endless   = ~stop_en;
      ap_eff    = 1'b0;
    end else if (stop_en && !ap && (s_eff < bl_len)) begin
      n_words   = s_eff;
      need_term = 1'b1;
      endless   = 1'b0;
      ap_eff    = 1'b0;
    end else begin
      n_words   = bl_len;
      need_term = 1'b0;
      endless   = 1'b0;
      ap_eff    = ap;
    end
  end
endmodule

// File: rtl/sdram_col_gen.sv
module sdram_col_gen #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [COL_W-1:0] start_col,
  input  logic             adv,
  input  logic             full,
  input  logic [1:0]       bl_sel,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] col_q, col_d, mask, col_inc;

  always_comb begin
    mask = full ? {COL_W{1'b1}} : ((COL_W'(1) << bl_sel) - COL_W'(1));
    col_inc = col_q + COL_W'(1);
    col_d = col_q;
    if (load)     col_d = start_col;
    else if (adv) col_d = (col_q & ~mask) | (col_inc & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              col_q <= '0;
    else if (load || adv)    col_q <= col_d;
  end

  assign col = col_q;

  p_block_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && !full) |=> ((col_q & ~$past(mask)) == ($past(col_q) & ~$past(mask))));

  p_page_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && full && (col_q == {COL_W{1'b1}})) |=> (col_q == '0));
endmodule

// File: rtl/sdram_rd_align.sv
module sdram_rd_align import sdram_seq_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int COL_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot,
  input  logic [COL_W-1:0]  slot_col,
  input  logic              cl3,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [COL_W-1:0]  rd_col
);
  logic             v_pipe [LAT_MAX];
  logic [COL_W-1:0] c_pipe [LAT_MAX];
  logic             tap_v;
  logic [COL_W-1:0] tap_c;

  for (genvar g = 0; g < LAT_MAX; g++) begin : g_stage
    logic             v_in;
    logic [COL_W-1:0] c_in;
    if (g == 0) begin : g_head
      assign v_in = slot;
      assign c_in = slot_col;
    end else begin : g_link
      assign v_in = v_pipe[g-1];
      assign c_in = c_pipe[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_pipe[g] <= 1'b0;
        c_pipe[g] <= '0;
      end else begin
        v_pipe[g] <= v_in;
        c_pipe[g] <= c_in;
      end
    end
  end

  always_comb begin
    tap_v = cl3 ? v_pipe[2] : v_pipe[1];
    tap_c = cl3 ? c_pipe[2] : c_pipe[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_col   <= '0;
    end else begin
      rd_valid <= tap_v;
      if (tap_v) begin
        rd_data <= dq_in;
        rd_col  <= tap_c;
      end
    end
  end

  p_rd_lag_cl2_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !cl3) |-> $past(slot, 3));

  p_rd_lag_cl3_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && cl3) |-> $past(slot, 4));
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq import sdram_seq_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int COL_W  = 10,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_bl_sel,
  input  logic              cfg_cl3,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_full_page,
  input  logic              req_auto_pre,
  input  logic              req_stop_en,
  input  logic [COL_W:0]    req_stop_cnt,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  output logic              busy,
  output logic [3:0]        cmd_n,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [COL_W-1:0]  cmd_col,
  output logic              cmd_ap,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic [COL_W-1:0]  wr_col,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              dqm,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [COL_W-1:0]  rd_col,
  output logic              pre_done,
  output logic [BANK_W-1:0] pre_bank
);
  localparam int CNT_W = COL_W + 1;

  seq_state_e        st_q, st_d;
  logic [CNT_W-1:0]  beat_q, beat_d, n_q;
  logic [1:0]        drain_q, drain_d;
  logic              term_q, endless_q, wr_q, ap_q, full_q, pre_q, pre_d;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  scol_q, col;
  logic [CNT_W-1:0]  p_n;
  logic              p_term, p_endless, p_ap;
  logic              accept, slot, first, last_slot;
  sdr_cmd_e          cmd_e;

  sdram_burst_plan #(.CNT_W(CNT_W)) u_plan (
    .full(req_full_page), .ap(req_auto_pre), .stop_en(req_stop_en),
    .stop_cnt(req_stop_cnt), .bl_sel(cfg_bl_sel),
    .n_words(p_n), .need_term(p_term), .endless(p_endless), .ap_eff(p_ap)
  );

  assign accept    = (st_q == ST_IDLE) && req_valid;
  assign slot      = (st_q == ST_BURST);
  assign first     = slot && (beat_q == '0);
  assign last_slot = slot && !endless_q && (beat_q == n_q - CNT_W'(1));

  // next state
  always_comb begin
    st_d    = st_q;
    beat_d  = beat_q;
    drain_d = drain_q;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_d   = ST_BURST;
          beat_d = '0;
        end
      end
      ST_BURST: begin
        beat_d = beat_q + CNT_W'(1);
        if (last_slot) begin
          if (term_q)    st_d = ST_TERM;
          else if (wr_q) st_d = ST_IDLE;
          else begin
            st_d    = ST_DRAIN;
            drain_d = cfg_cl3 ? 2'd3 : 2'd2;
          end
        end
      end
      ST_TERM: begin
        if (wr_q) st_d = ST_IDLE;
        else begin
          st_d    = ST_DRAIN;
          drain_d = cfg_cl3 ? 2'd2 : 2'd1;
        end
      end
      default: begin
        drain_d = drain_q - 2'd1;
        if (drain_q == 2'd1) st_d = ST_IDLE;
      end
    endcase
    pre_d = ap_q && (st_q != ST_IDLE) && (st_d == ST_IDLE);
  end

  // sequencing registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      beat_q  <= '0;
      drain_q <= '0;
      pre_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      beat_q  <= beat_d;
      drain_q <= drain_d;
      pre_q   <= pre_d;
    end
  end

  // request capture, enabled on accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q       <= '0;
      term_q    <= 1'b0;
      endless_q <= 1'b0;
      wr_q      <= 1'b0;
      ap_q      <= 1'b0;
      full_q    <= 1'b0;
      bank_q    <= '0;
      scol_q    <= '0;
    end else if (accept) begin
      n_q       <= p_n;
      term_q    <= p_term;
      endless_q <= p_endless;
      wr_q      <= req_write;
      ap_q      <= p_ap;
      full_q    <= req_full_page;
      bank_q    <= req_bank;
      scol_q    <= req_col;
    end
  end

  sdram_col_gen #(.COL_W(COL_W)) u_col (
    .clk(clk), .rst_n(rst_n), .load(accept), .start_col(req_col),
    .adv(slot), .full(full_q), .bl_sel(cfg_bl_sel), .col(col)
  );

  sdram_rd_align #(.DATA_W(DATA_W), .COL_W(COL_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .slot(slot && !wr_q), .slot_col(col),
    .cl3(cfg_cl3), .dq_in(dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_col(rd_col)
  );

  // command bus
  always_comb begin
    cmd_e = CMD_NOP;
    if (first)                 cmd_e = wr_q ? CMD_WRITE : CMD_READ;
    else if (st_q == ST_TERM)  cmd_e = CMD_BST;
  end

  assign cmd_n    = cmd_e;
  assign cmd_bank = bank_q;
  assign cmd_col  = first ? scol_q : '0;
  assign cmd_ap   = first && ap_q;

  // write data path
  assign wr_ready = slot && wr_q;
  assign dq_oe    = wr_ready;
  assign dq_out   = wr_ready ? wr_data : '0;
  assign dqm      = wr_ready && !wr_valid;
  assign wr_col   = col;

  assign busy     = (st_q != ST_IDLE);
  assign pre_done = pre_q;
  assign pre_bank = bank_q;

  p_write_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_n == CMD_WRITE) |-> (dq_oe && wr_ready));

  p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && !busy) |-> 1'b0);

  p_cmd_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ((cmd_n == CMD_READ) || (cmd_n == CMD_WRITE)));

  p_pre_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pre_done |-> (!busy && $past(busy)));

  p_rd_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (busy || $past(busy)));
endmodule

// File: tb/tb_sdram_burst_seq.sv
`timescale 1ns/1ps
module tb_sdram_burst_seq;
  localparam int DATA_W = 8;
  localparam int COL_W  = 10;
  localparam int BANK_W = 2;
  localparam int PAGE   = 1 << COL_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [1:0]        cfg_bl_sel;
  logic              cfg_cl3;
  logic              req_valid, req_write, req_full_page, req_auto_pre, req_stop_en;
  logic [COL_W:0]    req_stop_cnt;
  logic [BANK_W-1:0] req_bank;
  logic [COL_W-1:0]  req_col;
  logic              busy;
  logic [3:0]        cmd_n;
  logic [BANK_W-1:0] cmd_bank;
  logic [COL_W-1:0]  cmd_col;
  logic              cmd_ap;
  logic              wr_valid;
  logic [DATA_W-1:0] wr_data;
  logic              wr_ready;
  logic [COL_W-1:0]  wr_col;
  logic [DATA_W-1:0] dq_out;
  logic              dq_oe, dqm;
  logic [DATA_W-1:0] dq_in;
  logic              rd_valid;
  logic [DATA_W-1:0] rd_data;
  logic [COL_W-1:0]  rd_col;
  logic              pre_done;
  logic [BANK_W-1:0] pre_bank;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_burst_seq #(.DATA_W(DATA_W), .COL_W(COL_W), .BANK_W(BANK_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_bl_sel(cfg_bl_sel), .cfg_cl3(cfg_cl3),
    .req_valid(req_valid), .req_write(req_write), .req_full_page(req_full_page),
    .req_auto_pre(req_auto_pre), .req_stop_en(req_stop_en), .req_stop_cnt(req_stop_cnt),
    .req_bank(req_bank), .req_col(req_col), .busy(busy), .cmd_n(cmd_n),
    .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_ap(cmd_ap), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready), .wr_col(wr_col), .dq_out(dq_out),
    .dq_oe(dq_oe), .dqm(dqm), .dq_in(dq_in), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_col(rd_col), .pre_done(pre_done), .pre_bank(pre_bank)
  );

  function automatic int pat_rd(int c);
    return (c * 37 + 5) & 255;
  endfunction

  function automatic int pat_wr(int c);
    return (c * 11 + 60) & 255;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Generic burst scenario; expected values derive from the requirements.
  task automatic run_burst(input bit wr, input bit full, input bit ap, input bit sen,
                           input int stop, input int bank, input int col,
                           input bit cl3, input int blsel, input bit hold_req,
                           input int drop_beat);
    int bl, s, n, cl, blen, cC, mask, base, k;
    bit term, ap_e;
    string ct;
    bl = 1 << blsel;
    s  = (stop == 0) ? 1 : stop;                          // R11
    cl = cl3 ? 3 : 2;
    if (full) begin n = s; term = 1'b1; ap_e = 1'b0; end
    else if (sen && !ap && s < bl) begin n = s; term = 1'b1; ap_e = 1'b0; end
    else begin n = bl; term = 1'b0; ap_e = ap; end
    blen = wr ? n + int'(term) : n + cl;
    mask = full ? PAGE - 1 : bl - 1;
    base = col & ~mask;
    ct   = full ? "R5" : "R4";

    @(negedge clk);
    cfg_cl3 = cl3; cfg_bl_sel = 2'(blsel);
    req_write = wr; req_full_page = full; req_auto_pre = ap; req_stop_en = sen;
    req_stop_cnt = (COL_W+1)'(stop); req_bank = BANK_W'(bank); req_col = COL_W'(col);
    req_valid = 1'b1;
    for (int i = 0; i < blen + 2; i++) begin
      @(negedge clk);
      if (i == 0) cC = cyc;
      req_valid = hold_req && (i < blen);
      wr_valid  = (i != drop_beat);
      wr_data   = DATA_W'(pat_wr(cyc));
      dq_in     = DATA_W'(pat_rd(cyc));
      #1;
      if (i == 0) begin
        chk("R1", "command", cmd_n, wr ? 4 : 5);
        chk("R1", "cmd_bank", cmd_bank, bank);
        chk("R1", "cmd_col", cmd_col, col);
        chk("R8", "cmd_ap", cmd_ap, ap_e);
      end else begin
        if (term && i == n) chk(full ? "R5" : "R7", "terminate", cmd_n, 6);
        else                chk("R1", "nop", cmd_n, 7);
        chk("R1", "cmd_col idle", cmd_col, 0);
      end
      if (wr) begin
        chk(i < n ? "R2" : "R3", "dq_oe", dq_oe, i < n);
        chk(i < n ? "R2" : "R3", "wr_ready", wr_ready, i < n);
        if (i < n) begin
          chk("R2", "dq_out", dq_out, pat_wr(cC + i));
          chk(ct, "wr_col", wr_col, base | ((col + i) & mask));
          chk("R10", "dqm", dqm, i == drop_beat);
        end
      end else begin
        chk("R2", "dq_oe on read", dq_oe, 0);
        k = i - cl - 1;
        chk(term ? "R7" : "R6", "rd_valid", rd_valid, (k >= 0) && (k < n));
        if (k >= 0 && k < n) begin
          chk("R6", "rd_data", rd_data, pat_rd(cC + i - 1));
          chk(ct, "rd_col", rd_col, base | ((col + k) & mask));
        end
      end
      chk("R9", "busy", busy, i < blen);
      chk("R8", "pre_done", pre_done, ap_e && (i == blen));
      if (ap_e && i == blen) chk("R8", "pre_bank", pre_bank, bank);
    end
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_full_page = 1'b0;
    req_auto_pre = 1'b0; req_stop_en = 1'b0; req_stop_cnt = '0; req_bank = '0;
    req_col = '0; cfg_bl_sel = 2'd0; cfg_cl3 = 1'b0; wr_valid = 1'b1;
    wr_data = '0; dq_in = '0;
    repeat (3) @(negedge clk);
    chk("R9", "reset busy", busy, 0);
    chk("R1", "reset cmd", cmd_n, 7);
    chk("R3", "reset dq_oe", dq_oe, 0);
    chk("R6", "reset rd_valid", rd_valid, 0);
    chk("R8", "reset pre_done", pre_done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // R2 R3 R4: write BL4 mid-block, request held while busy (R9)
  task automatic t_write_bl4();   run_burst(1, 0, 0, 0, 0, 2, 6, 0, 2, 1, -1); endtask
  // R4 R6: read BL8, CL3, start inside block
  task automatic t_read_bl8();    run_burst(0, 0, 0, 0, 0, 1, 13, 1, 3, 0, -1); endtask
  // R6: read BL2, CL2
  task automatic t_read_bl2();    run_burst(0, 0, 0, 0, 0, 3, 101, 0, 1, 0, -1); endtask
  // R2 R3: single-word write
  task automatic t_write_bl1();   run_burst(1, 0, 0, 0, 0, 0, 77, 0, 0, 0, -1); endtask
  // R5: full-page write across the page end
  task automatic t_write_page();  run_burst(1, 1, 0, 1, 5, 1, PAGE - 2, 0, 2, 0, -1); endtask
  // R5 R7: full-page read, CL3, wraps and terminates
  task automatic t_read_page();   run_burst(0, 1, 0, 1, 3, 2, PAGE - 1, 1, 3, 0, -1); endtask
  // R7: early stop on fixed read, CL2
  task automatic t_read_stop();   run_burst(0, 0, 0, 1, 3, 0, 40, 0, 3, 0, -1); endtask
  // R7: early stop on fixed write
  task automatic t_write_stop();  run_burst(1, 0, 0, 1, 2, 3, 9, 1, 3, 0, -1); endtask
  // R8: auto-precharge write, stop request ignored
  task automatic t_ap_write();    run_burst(1, 0, 1, 1, 2, 2, 20, 0, 2, 0, -1); endtask
  // R8: auto-precharge read, CL3
  task automatic t_ap_read();     run_burst(0, 0, 1, 0, 0, 1, 50, 1, 2, 0, -1); endtask
  // R10: masked write beat
  task automatic t_mask();        run_burst(1, 0, 0, 0, 0, 0, 16, 0, 3, 0, 2); endtask
  // R11: zero stop count on full-page read
  task automatic t_stop_zero();   run_burst(0, 1, 0, 1, 0, 0, 300, 0, 0, 0, -1); endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_write_bl4();
    t_read_bl8();
    t_read_bl2();
    t_write_bl1();
    t_write_page();
    t_read_page();
    t_read_stop();
    t_write_stop();
    t_ap_write();
    t_ap_read();
    t_mask();
    t_stop_zero();
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule